// File: doc/BRIEF.md
# Keyed configuration item read port

This block is a small register target through which a host pulls configuration items out of a read-only table. The host first writes a 16-bit key to pick an item. It then reads the item's bytes through a data port, one to eight bytes per access. Each select rewinds the stream to the start of the item. Every read returns the next bytes of the item, packed most significant first, and advances a byte offset. Once the item is used up, the missing byte lanes read as zero.

Keys fall into two banks. The top key bit picks the bank, and the low fourteen bits index an entry within that bank. An index at or beyond the table size leaves the port with no valid item, and reads then return zero. The item table is a computed ROM with a base address and a length for each entry. An entry of length zero has no data.

Three address spaces share one valid/ready request channel:
- a write-only control register that takes the key;
- a wide data register;
- a combined byte-wide space, where a one-byte access is data and a two-byte write is a select.

Every accepted request gets a registered response one cycle later. A request that is not legal has no side effect and returns zero.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the port selects key 0 (bank 0, index 0) with offset 0. A 4-byte data read returns that entry's four bytes.
- R2: A select always clears the byte offset to zero. Reselecting the current key restarts the stream from byte 0.
- R3: Key bit 15 selects the bank. Key bits 13:0 give the index. Key bit 14 is ignored.
- R4: A select whose index is at or above FIRST_FILE+FILE_SLOTS (64 by default) makes the selection invalid. Every data read then returns zero.
- R5: Entry (b,i) has length L = (5*i + 3*b + 4) mod (MAX_LEN+1), with MAX_LEN = 16. Byte j of the entry is (29*A + 7) mod 256, where A = (b*64 + i)*16 + j. An N-byte read returns the next bytes at result byte lanes N-1 down to 0, first byte most significant. It advances the offset by one per byte delivered.
- R6: If the item ends partway through a read, the remaining lower lanes are zero and the offset stops at L.
- R7: A read at or past the end of the item, or of a zero-length entry, returns zero.
- R8: In the combined space (space code 2), a 1-byte read is a data read and a 2-byte write is a select. A 1-byte write has no effect. Any other size returns zero and has no effect.
- R9: In the control space (space code 0), a 2-byte write is a select. Reads return zero. Writes of any other size have no effect.
- R10: In the data space (space code 1), only reads at address 0 with size 1 to 8 are legal. Reads at other addresses or of other sizes return zero and do not move the offset. Writes have no effect.
- R11: Each accepted request gives exactly one rsp_valid pulse, in the cycle after acceptance. When no request is accepted, rsp_valid stays low.
- R12: Space code 3 is rejected: it returns zero and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 0 control, 1 data, 2 combined, 3 unused |
| req_addr | input | 3 | Byte address within the space |
| req_size | input | SZ_W (4) | Access size in bytes |
| req_wdata | input | 16 | Write data (key for selects) |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | BUS_BYTES*8 (64) | Read data, zero for writes and rejected accesses |

## Verification
The hardest state to reach from the ports is a read that straddles the end of an item. It needs the right mix of entry length, current offset and access size, after an arbitrary history of selects and illegal accesses that must not disturb the offset. The stimulus reaches it with a seeded random stream of selects that leans on short entries and boundary indices, interleaved with reads of every size and with rejected accesses. Directed cases add reads that split a 4-byte item across 3-byte accesses, zero-length entries, and indices on either side of the table limit.

// File: rtl/cfg_item_port.sv
module cfg_item_port #(
  parameter int FIRST_FILE = 32,
  parameter int FILE_SLOTS = 32,
  parameter int MAX_LEN    = 16,
  parameter int BUS_BYTES  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [1:0]                    req_space,
  input  logic [2:0]                    req_addr,
  input  logic [$clog2(BUS_BYTES+1)-1:0] req_size,
  input  logic [15:0]                   req_wdata,
  output logic                          rsp_valid,
  output logic [BUS_BYTES*8-1:0]        rsp_rdata
);
  localparam int ENTRIES = FIRST_FILE + FILE_SLOTS;
  localparam int OFF_W   = $clog2(MAX_LEN + 1);
  localparam int SZ_W    = $clog2(BUS_BYTES + 1);
  localparam int DW      = BUS_BYTES * 8;
  localparam logic [1:0] SP_CTL = 2'd0, SP_DATA = 2'd1, SP_COMB = 2'd2;

  function automatic int item_len(input logic bank, input int idx);
    return (5 * idx + 3 * int'(bank) + 4) % (MAX_LEN + 1);
  endfunction

  function automatic logic [7:0] item_byte(input int a);
    int v;
    v = 29 * a + 7;
    return v[7:0];
  endfunction

  logic             sel_bank;
  logic [15:0]      sel_idx;
  logic             sel_ok;
  logic [OFF_W-1:0] offset;

  logic             acc, is_sel, is_rd, rd_data_sp, rd_comb_sp;
  logic [DW-1:0]    rd_val;
  int               cur_len, base, consumed, rsz;

  assign req_ready  = 1'b1;
  assign acc        = req_valid & req_ready;
  assign is_sel     = acc & req_write & (req_size == SZ_W'(2)) &
                      (req_space == SP_CTL | req_space == SP_COMB);
  assign rd_data_sp = (req_space == SP_DATA) & (req_addr == 3'd0) &
                      (req_size != '0) & (req_size <= SZ_W'(BUS_BYTES));
  assign rd_comb_sp = (req_space == SP_COMB) & (req_size == SZ_W'(1));
  assign is_rd      = acc & ~req_write & (rd_data_sp | rd_comb_sp);

  assign cur_len = sel_ok ? item_len(sel_bank, int'(sel_idx)) : 0;
  assign base    = (int'(sel_bank) * ENTRIES + int'(sel_idx)) * MAX_LEN;
  assign rsz     = (int'(req_size) > BUS_BYTES) ? BUS_BYTES : int'(req_size);

  always_comb begin
    rd_val   = '0;
    consumed = 0;
    for (int k = 0; k < BUS_BYTES; k++) begin
      if (k < rsz && int'(offset) + k < cur_len) begin
        rd_val[(rsz - 1 - k) * 8 +: 8] = item_byte(base + int'(offset) + k);
        consumed = consumed + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_bank  <= 1'b0;
      sel_idx   <= '0;
      sel_ok    <= 1'b1;
      offset    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_rdata <= is_rd ? rd_val : '0;
      if (is_sel) begin
        sel_bank <= req_wdata[15];
        sel_idx  <= req_wdata & 16'h3FFF;
        sel_ok   <= (req_wdata & 16'h3FFF) < 16'(ENTRIES);
        offset   <= '0;
      end else if (is_rd) begin
        offset <= OFF_W'(int'(offset) + consumed);
      end
    end
  end
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
  parameter int OFF_W   = 5,
  parameter int SZ_W    = 4,
  parameter int DW      = 64,
  parameter int MAX_LEN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [1:0]       req_space,
  input logic [2:0]       req_addr,
  input logic [SZ_W-1:0]  req_size,
  input logic             rsp_valid,
  input logic [DW-1:0]    rsp_rdata,
  input logic             sel_ok,
  input logic [OFF_W-1:0] offset
);
  // R11
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R11
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R9
  ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_space == 2'd0) |=> rsp_rdata == '0);
  // R10
  data_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'd1 && req_addr != 3'd0) |=> rsp_rdata == '0);
  // R12
  bad_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'd3) |=> (rsp_rdata == '0 && $stable(offset)));
  // R2
  sel_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_space == 2'd0 && req_size == SZ_W'(2)) |=> offset == '0);
  // R4
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sel_ok && !(req_write && req_size == SZ_W'(2))) |=> rsp_rdata == '0);
  // R5
  byte_read_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == SZ_W'(1)) |=> rsp_rdata[DW-1:8] == '0);
  // R6
  offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(offset) <= MAX_LEN);
endmodule

bind cfg_item_port cfg_item_port_chk #(
  .OFF_W(OFF_W), .SZ_W(SZ_W), .DW(DW), .MAX_LEN(MAX_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_space(req_space), .req_addr(req_addr), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sel_ok(sel_ok), .offset(offset)
);

// File: tb/cfg_item_port_tb.sv
module cfg_item_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [1:0]  req_space = '0;
  logic [2:0]  req_addr = '0;
  logic [3:0]  req_size = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;

  int checks = 0, fails = 0;
  int m_bank = 0, m_idx = 0, m_ok = 1, m_off = 0;

  always #5 clk = ~clk;

  cfg_item_port dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_space(req_space), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  function automatic int mlen();
    return m_ok ? (5 * m_idx + 3 * m_bank + 4) % 17 : 0;
  endfunction

  function automatic logic [7:0] mbyte(int j);
    int a;
    a = (m_bank * 64 + m_idx) * 16 + j;
    return 8'((29 * a + 7) % 256);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] sp, input logic [2:0] ad,
                        input logic [3:0] sz, input logic [15:0] wd, input string req);
    logic [63:0] exp;
    int len;
    bit lsel, lrd;
    exp  = '0;
    lsel = w && sz == 4'd2 && (sp == 2'd0 || sp == 2'd2);
    lrd  = !w && ((sp == 2'd1 && ad == 3'd0 && sz >= 1 && sz <= 8) ||
                  (sp == 2'd2 && sz == 4'd1));
    if (lrd) begin
      len = mlen();
      for (int k = 0; k < int'(sz); k++) begin
        if (m_off < len) begin
          exp[(int'(sz) - 1 - k) * 8 +: 8] = mbyte(m_off);
          m_off++;
        end
      end
    end
    if (lsel) begin
      m_bank = int'(wd[15]);
      m_idx  = int'(wd[13:0]);
      m_ok   = (m_idx < 64) ? 1 : 0;
      m_off  = 0;
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_space = sp; req_addr = ad;
    req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11", 64'(rsp_valid), 64'd1);
    check(req, rsp_rdata, exp);
  endtask

  task automatic sel(input logic [15:0] key, input string req);
    access(1'b1, 2'd0, 3'd0, 4'd2, key, req);
  endtask

  task automatic rd(input logic [3:0] sz, input string req);
    access(1'b0, 2'd1, 3'd0, sz, 16'h0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    rd(4'd4, "R1");
    rd(4'd3, "R7");
    sel(16'h0000, "R2");
    rd(4'd3, "R2");
    rd(4'd3, "R6");
    rd(4'd2, "R7");
    sel(16'h4003, "R3");
    rd(4'd8, "R3");
    sel(16'h0003, "R3");
    rd(4'd8, "R3");
    sel(16'h8002, "R3");
    rd(4'd8, "R7");
    sel(16'h0006, "R7");
    rd(4'd4, "R7");
    sel(16'h003F, "R4");
    rd(4'd8, "R4");
    sel(16'h0040, "R4");
    rd(4'd8, "R4");
    access(1'b1, 2'd2, 3'd0, 4'd2, 16'h0001, "R8");
    access(1'b0, 2'd2, 3'd0, 4'd1, 16'h0, "R8");
    access(1'b1, 2'd2, 3'd0, 4'd1, 16'hFFFF, "R8");
    access(1'b0, 2'd2, 3'd0, 4'd2, 16'h0, "R8");
    access(1'b0, 2'd2, 3'd0, 4'd1, 16'h0, "R8");
    access(1'b0, 2'd0, 3'd0, 4'd2, 16'h0, "R9");
    access(1'b1, 2'd0, 3'd0, 4'd1, 16'h0005, "R9");
    rd(4'd2, "R9");
    access(1'b0, 2'd1, 3'd4, 4'd4, 16'h0, "R10");
    rd(4'd0, "R10");
    rd(4'd9, "R10");
    access(1'b1, 2'd1, 3'd0, 4'd2, 16'h0007, "R10");
    rd(4'd2, "R10");
    access(1'b1, 2'd3, 3'd0, 4'd2, 16'h0009, "R12");
    access(1'b0, 2'd3, 3'd0, 4'd1, 16'h0, "R12");
    rd(4'd8, "R5");
    for (int n = 0; n < 600; n++) begin
      int c;
      logic [15:0] key;
      c = int'($urandom % 10);
      if (c < 2) begin
        key = 16'($urandom % 70);
        if ($urandom % 2 == 1) key[15] = 1'b1;
        if ($urandom % 4 == 0) key[14] = 1'b1;
        if ($urandom % 2 == 0) sel(key, "R3");
        else access(1'b1, 2'd2, 3'($urandom), 4'd2, key, "R8");
      end else if (c < 7) begin
        rd(4'(1 + $urandom % 8), "R5");
      end else if (c < 8) begin
        access(1'b0, 2'd2, 3'($urandom), 4'(1 + $urandom % 3), 16'h0, "R8");
      end else begin
        access(1'($urandom), 2'($urandom), 3'($urandom), 4'($urandom),
               16'($urandom), "R6");
      end
    end
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule